// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. A host writes bytes into a 64-entry transmit queue, and the transmitter sends them out as framed characters. The receiver rebuilds characters from the incoming line and stores them in a 64-entry receive queue, where the host reads them. The host can see how many bytes each queue holds at all times.

The frame shape can be changed at run time, while both directions are idle. It has 7 or 8 data bits, an optional even or odd parity bit and 1 or 2 stop bits. All bit timing comes from a tick at sixteen times the bit rate. That tick is made either by an internal programmable divider or from rising edges on an external clock pin. When the internal divider is used, the tick is also driven out. The receiver keeps sticky flags for framing, parity, overrun and break. Flow control uses a clear-to-send input, which gates the start of each character, and a ready-to-send output, which drops when the receive queue reaches a programmable level.

Top module: `sio_fifo_uart`

## Requirements
- R1: Each direction has a 64-entry queue. `tx_count` and `rx_count` give the number of stored bytes. A write to a full transmit queue is dropped, and `tx_full`/`rx_full` are high exactly at 64 entries.
- R2: The least significant data bit is sent and received first. When `cfg_data7`=1 only 7 data bits are framed, and a received byte has bit 7 set to 0.
- R3: When `cfg_par_en`=1 a parity bit follows the data bits. It is computed over the data bits only: even parity when `cfg_par_odd`=0, odd parity when it is 1. A received parity mismatch sets the sticky `err_parity`, and the byte is still stored.
- R4: A character is 1 start bit, then 7 or 8 data bits, then 0 or 1 parity bit, then 1 stop bit (`cfg_stop2`=0) or 2 stop bits (`cfg_stop2`=1), each 16 ticks long. The line is high (1) when idle and during stop bits, and the start bit is low (0).
- R5: When `cfg_ext_clk`=0, a tick occurs every `baud_div`+1 clock cycles and each tick pulses `tick_out` for one cycle. When `cfg_ext_clk`=1, each rising edge of `ext_clk_pin` is one tick and `tick_out` stays 0.
- R6: A low first stop bit on a received character that is not a break sets the sticky `err_frame`. The byte is still stored.
- R7: A character whose data bits, parity bit and first stop bit are all low sets the sticky `err_break`. It stores no byte and does not set `err_frame`.
- R8: A character that completes while the receive queue is full sets the sticky `err_overrun` and is discarded. The stored bytes are kept in order.
- R9: The transmitter starts a character only while `cts`=1. A character already started always completes, and with `cts`=0 the line stays high.
- R10: `rts` is 1 while `rx_count` < `rts_level` and 0 otherwise.
- R11: The receiver confirms a start bit at the 8th tick after the falling edge. A low pulse shorter than that is ignored, and each later bit is sampled at its 16th tick, which is mid-bit.
- R12: After reset `txd`=1, both counts are 0, all error flags are 0, `rx_ready`=0, and the flags stay set until `err_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits sent |
| cfg_ext_clk | input | 1 | 1: tick from external pin, 0: internal divider |
| baud_div | input | DIV_W | Internal divider; tick period is baud_div+1 cycles |
| rts_level | input | CW | Receive queue level at which rts drops |
| ext_clk_pin | input | 1 | External 16x bit-rate clock |
| tick_out | output | 1 | Internal 16x tick pulse |
| wr_en | input | 1 | Push wr_data into transmit queue |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Pop the receive queue |
| rd_data | output | 8 | Oldest received byte (valid while rx_ready) |
| tx_count | output | CW | Bytes in transmit queue |
| rx_count | output | CW | Bytes in receive queue |
| tx_full | output | 1 | Transmit queue full |
| rx_full | output | 1 | Receive queue full |
| rx_ready | output | 1 | Receive queue not empty |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_break | output | 1 | Sticky break detected |
| err_clr | input | 1 | Clears all error flags |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear to send (1 = may start) |
| rts | output | 1 | Ready to send (1 = room in receive queue) |

## Verification
A shifter counter that slips by one tick shows up within a single character. It moves the sample point off mid-bit, so the received byte changes, or the spacing between falling edges of `txd` drifts. A wrong queue pointer or count shows up at the next read as bytes out of order or as a count that disagrees with the number of writes. A bad parity or break decision sets a sticky flag, or fails to set one, by the end of the stop bit. The bench therefore compares every byte and flag one character time after it is stimulated, both in loopback under random frame formats and against directed line waveforms.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef struct packed {
        logic data7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
        logic       par_err;
        logic       brk;
    } rx_result_t;

    localparam int TICKS_PER_BIT = 16;
    localparam int START_CONFIRM = TICKS_PER_BIT / 2 - 1;

    function automatic logic parity_of(logic [7:0] d, frame_cfg_t c);
        logic p;
        p = c.data7 ? ^d[6:0] : ^d;
        return p ^ c.par_odd;
    endfunction

    function automatic logic [2:0] last_bit(frame_cfg_t c);
        return c.data7 ? 3'd6 : 3'd7;
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tick.sv
module uart_tick #(
    parameter int DIV_W  = 16,
    parameter int SYNC_N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_pin,
    output logic             tick,
    output logic             tick_out
);
    logic [DIV_W-1:0]  div_cnt;
    logic [SYNC_N-1:0] ext_q;
    logic              int_tick, ext_tick;

    assign int_tick = (div_cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)           div_cnt <= '0;
        else if (int_tick) div_cnt <= '0;
        else               div_cnt <= div_cnt + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ext_q[0] <= 1'b0;
                    else     ext_q[0] <= ext_pin;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) ext_q[g] <= 1'b0;
                    else     ext_q[g] <= ext_q[g-1];
                end
            end
        end
    endgenerate

    assign ext_tick = ext_q[SYNC_N-2] && !ext_q[SYNC_N-1];
    assign tick     = ext_sel ? ext_tick : int_tick;
    assign tick_out = !ext_sel && int_tick;
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       cts_ok,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd
);
    tx_state_t  state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       pbit;
    logic       second_stop;
    logic       bit_end;

    assign q_pop   = (state == TX_IDLE) && !q_empty && cts_ok;
    assign bit_end = tick && (tcnt == 4'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= TX_IDLE;
            tcnt        <= '0;
            bidx        <= '0;
            sh          <= '0;
            pbit        <= 1'b0;
            second_stop <= 1'b0;
            txd         <= 1'b1;
        end else begin
            if (state != TX_IDLE && tick)
                tcnt <= bit_end ? 4'd0 : tcnt + 4'd1;
            case (state)
                TX_IDLE: begin
                    txd <= 1'b1;
                    if (q_pop) begin
                        sh    <= q_data;
                        pbit  <= parity_of(q_data, cfg);
                        bidx  <= '0;
                        tcnt  <= '0;
                        txd   <= 1'b0;
                        state <= TX_START;
                    end
                end
                TX_START: if (bit_end) begin
                    txd   <= sh[0];
                    state <= TX_DATA;
                end
                TX_DATA: if (bit_end) begin
                    if (bidx == last_bit(cfg)) begin
                        second_stop <= 1'b0;
                        if (cfg.par_en) begin
                            txd   <= pbit;
                            state <= TX_PAR;
                        end else begin
                            txd   <= 1'b1;
                            state <= TX_STOP;
                        end
                    end else begin
                        sh   <= sh >> 1;
                        txd  <= sh[1];
                        bidx <= bidx + 3'd1;
                    end
                end
                TX_PAR: if (bit_end) begin
                    txd   <= 1'b1;
                    state <= TX_STOP;
                end
                TX_STOP: if (bit_end) begin
                    if (cfg.stop2 && !second_stop) second_stop <= 1'b1;
                    else                           state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       line,
    output logic       done,
    output rx_result_t res
);
    rx_state_t  state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       pbit;
    logic       all_low;
    logic       prev;
    logic       mid;

    assign mid = tick && (tcnt == 4'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            pbit    <= 1'b0;
            all_low <= 1'b0;
            prev    <= 1'b1;
            done    <= 1'b0;
            res     <= '0;
        end else begin
            prev <= line;
            done <= 1'b0;
            if (state != RX_IDLE && state != RX_START && tick)
                tcnt <= mid ? 4'd0 : tcnt + 4'd1;
            case (state)
                RX_IDLE: if (prev && !line) begin
                    tcnt  <= '0;
                    state <= RX_START;
                end
                RX_START: if (tick) begin
                    if (tcnt == 4'(START_CONFIRM)) begin
                        tcnt <= '0;
                        if (line) begin
                            state <= RX_IDLE;
                        end else begin
                            bidx    <= '0;
                            sh      <= '0;
                            all_low <= 1'b1;
                            state   <= RX_DATA;
                        end
                    end else begin
                        tcnt <= tcnt + 4'd1;
                    end
                end
                RX_DATA: if (mid) begin
                    sh[bidx] <= line;
                    all_low  <= all_low && !line;
                    if (bidx == last_bit(cfg))
                        state <= cfg.par_en ? RX_PAR : RX_STOP;
                    else
                        bidx <= bidx + 3'd1;
                end
                RX_PAR: if (mid) begin
                    pbit    <= line;
                    all_low <= all_low && !line;
                    state   <= RX_STOP;
                end
                RX_STOP: if (mid) begin
                    done          <= 1'b1;
                    res.data      <= sh;
                    res.frame_err <= !line;
                    res.brk       <= !line && all_low;
                    res.par_err   <= cfg.par_en && (pbit != parity_of(sh, cfg));
                    state         <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio_fifo_uart.sv
module sio_fifo_uart
    import uart_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DIV_W = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_data7,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_stop2,
    input  logic             cfg_ext_clk,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [CW-1:0]    rts_level,
    input  logic             ext_clk_pin,
    output logic             tick_out,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic [CW-1:0]    tx_count,
    output logic [CW-1:0]    rx_count,
    output logic             tx_full,
    output logic             rx_full,
    output logic             rx_ready,
    output logic             err_frame,
    output logic             err_parity,
    output logic             err_overrun,
    output logic             err_break,
    input  logic             err_clr,
    output logic             txd,
    input  logic             rxd,
    input  logic             cts,
    output logic             rts
);
    frame_cfg_t cfg;
    logic       tick;
    logic [1:0] cts_q, rxd_q;
    logic       tx_empty, tx_pop;
    logic [7:0] tx_data;
    logic       rx_done, rx_push, rx_empty;
    rx_result_t rx_res;

    always_comb begin
        cfg.data7   = cfg_data7;
        cfg.par_en  = cfg_par_en;
        cfg.par_odd = cfg_par_odd;
        cfg.stop2   = cfg_stop2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_q <= 2'b00;
            rxd_q <= 2'b11;
        end else begin
            cts_q <= {cts_q[0], cts};
            rxd_q <= {rxd_q[0], rxd};
        end
    end

    uart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .ext_sel(cfg_ext_clk), .div(baud_div),
        .ext_pin(ext_clk_pin), .tick(tick), .tick_out(tick_out)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_txq (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(tx_pop),
        .dout(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .cts_ok(cts_q[1]),
        .q_empty(tx_empty), .q_data(tx_data), .q_pop(tx_pop), .txd(txd)
    );

    uart_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .line(rxd_q[1]),
        .done(rx_done), .res(rx_res)
    );

    assign rx_push = rx_done && !rx_res.brk && !rx_full;

    uart_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_res.data), .pop(rd_en),
        .dout(rd_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign rx_ready = !rx_empty;
    assign rts      = (rx_count < rts_level);

    always_ff @(posedge clk) begin
        if (rst || err_clr) begin
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            err_break   <= 1'b0;
        end else if (rx_done) begin
            if (rx_res.brk) begin
                err_break <= 1'b1;
            end else if (rx_full) begin
                err_overrun <= 1'b1;
            end else begin
                if (rx_res.frame_err) err_frame  <= 1'b1;
                if (rx_res.par_err)   err_parity <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_fifo_uart_chk.sv
module sio_fifo_uart_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          rx_full,
    input logic          cfg_ext_clk,
    input logic          tick_out,
    input logic          rts,
    input logic          err_frame,
    input logic          err_parity,
    input logic          err_overrun,
    input logic          err_break,
    input logic          err_clr,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] rts_level
);
    p_count_limit_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (int'(rx_count) <= int'($past(rx_count)) + 1) &&
        (int'(rx_count) + 1 >= int'($past(rx_count))));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        rx_full && !rd_en |=> rx_full);

    p_no_tick_out_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_ext_clk && $past(cfg_ext_clk) |-> !tick_out);

    p_rts_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= rts_level) |-> !rts);

    p_frame_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_frame && !err_clr |=> err_frame);

    p_parity_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        err_parity && !err_clr |=> err_parity);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_overrun && !err_clr |=> err_overrun);

    p_break_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_break && !err_clr |=> err_break);

    p_break_no_store_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_break) |-> (rx_count <= $past(rx_count)));
endmodule

bind sio_fifo_uart sio_fifo_uart_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/test_sio_fifo_uart.sv
module test_sio_fifo_uart;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_data7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_ext_clk = 0;
    logic [15:0] baud_div = 16'd1;
    logic [6:0] rts_level = 7'd3;
    logic       ext_clk_pin = 1'b0;
    logic       tick_out;
    logic       wr_en = 0, rd_en = 0, err_clr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [6:0] tx_count, rx_count;
    logic       tx_full, rx_full, rx_ready;
    logic       err_frame, err_parity, err_overrun, err_break;
    logic       txd, rts;
    logic       cts = 1'b1;
    logic       loop = 1'b0;
    logic       rx_drv = 1'b1;
    logic       rxd;
    int         checks = 0, errors = 0;
    int         cyc = 0;
    bit         done_flag = 0;

    assign rxd = loop ? txd : rx_drv;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        repeat (4) @(negedge clk);
        ext_clk_pin = ~ext_clk_pin;
    end

    sio_fifo_uart i_sio_fifo_uart (
        .clk(clk), .rst(rst), .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_ext_clk(cfg_ext_clk),
        .baud_div(baud_div), .rts_level(rts_level), .ext_clk_pin(ext_clk_pin),
        .tick_out(tick_out), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full), .rx_ready(rx_ready),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .err_break(err_break), .err_clr(err_clr), .txd(txd), .rxd(rxd),
        .cts(cts), .rts(rts)
    );

    function automatic logic exp_par(logic [7:0] d, logic d7, logic odd);
        return (d7 ? ^d[6:0] : ^d) ^ odd;
    endfunction

    function automatic int bit_time();
        return cfg_ext_clk ? 16 * 8 : 16 * (int'(baud_div) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] d);
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_errs();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic drive_frame(input logic [7:0] d, input int nb, input bit pen,
                               input bit pb, input bit stopv);
        int bt;
        bt = bit_time();
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_drv = d[i];
            repeat (bt) @(negedge clk);
        end
        if (pen) begin
            rx_drv = pb;
            repeat (bt) @(negedge clk);
        end
        rx_drv = stopv;
        repeat (bt) @(negedge clk);
        rx_drv = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic tx_capture(input int nb, input int drop_bit, output logic [7:0] d,
                              output int t_fall);
        int bt;
        bt = bit_time();
        d = 8'h00;
        while (txd !== 1'b0) @(negedge clk);
        t_fall = cyc;
        repeat (bt + bt / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            d[i] = txd;
            if (i == drop_bit) cts = 1'b0;
            if (i != nb - 1) repeat (bt) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] expq [6];
        int t0, t1, n, lows, bt;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(txd === 1'b1, "R12 txd idle", txd, 1);
        check(tx_count == 0 && rx_count == 0, "R12 counts", {tx_count, rx_count}, 0);
        check({err_frame, err_parity, err_overrun, err_break} == 4'b0, "R12 flags",
              {err_frame, err_parity, err_overrun, err_break}, 0);
        check(rx_ready == 1'b0 && rts == 1'b1, "R12 ready/rts", {rx_ready, rts}, 1);

        // R5 internal tick rate: div=1 -> one tick every 2 cycles
        n = 0;
        for (int i = 0; i < 320; i++) begin
            @(negedge clk);
            if (tick_out) n++;
        end
        check(n == 160, "R5 internal tick count", n, 160);

        // R2/R4 transmit waveform: 8 data, no parity, 2 stop bits
        cfg_stop2 = 1'b1;
        bt = bit_time();
        push_tx(8'hA5);
        push_tx(8'h3C);
        tx_capture(8, -1, got, t0);
        check(got == 8'hA5, "R2 tx LSB first", got, 8'hA5);
        tx_capture(8, -1, got, t1);
        check(got == 8'h3C, "R2 tx second byte", got, 8'h3C);
        n = t1 - t0;
        check(n >= 11 * bt - 4 && n <= 11 * bt + 4, "R4 char length 2 stop", n, 11 * bt);
        repeat (4 * bt) @(negedge clk);
        cfg_stop2 = 1'b0;

        // R9 clear-to-send gating
        cts = 1'b0;
        push_tx(8'hC3);
        push_tx(8'h11);
        lows = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0, "R9 held while cts low", lows, 0);
        check(tx_count == 2, "R9 queue held", tx_count, 2);
        cts = 1'b1;
        tx_capture(8, 2, got, t0);
        check(got == 8'hC3, "R9 frame completes after cts drop", got, 8'hC3);
        repeat (bt) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0 && tx_count == 1, "R9 next char waits", {lows[7:0], 1'b0, tx_count}, 1);
        cts = 1'b1;
        repeat (12 * bt) @(negedge clk);

        // R1 transmit queue full
        do_reset();
        cts = 1'b0;
        for (int i = 0; i < 70; i++) push_tx(8'(i));
        check(tx_count == 64, "R1 tx count saturates", tx_count, 64);
        check(tx_full == 1'b1, "R1 tx full", tx_full, 1);
        cts = 1'b1;
        do_reset();

        // R2 receive LSB first and 7-bit length
        cfg_data7 = 1'b1;
        drive_frame(8'hD5, 7, 0, 0, 1);
        pop_rx(got);
        check(got == 8'h55, "R2 rx 7-bit", got, 8'h55);
        cfg_data7 = 1'b0;
        drive_frame(8'h01, 8, 0, 0, 1);
        pop_rx(got);
        check(got == 8'h01, "R2 rx lsb", got, 8'h01);
        drive_frame(8'h80, 8, 0, 0, 1);
        pop_rx(got);
        check(got == 8'h80, "R2 rx msb", got, 8'h80);

        // R3 parity
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        drive_frame(8'h37, 8, 1, exp_par(8'h37, 0, 0), 1);
        check(err_parity == 1'b0, "R3 even parity ok", err_parity, 0);
        pop_rx(got);
        drive_frame(8'h37, 8, 1, !exp_par(8'h37, 0, 0), 1);
        check(err_parity == 1'b1, "R3 parity error", err_parity, 1);
        pop_rx(got);
        check(got == 8'h37, "R3 byte kept on parity error", got, 8'h37);
        clear_errs();
        cfg_par_odd = 1'b1;
        drive_frame(8'h0F, 8, 1, exp_par(8'h0F, 0, 1), 1);
        check(err_parity == 1'b0, "R3 odd parity ok", err_parity, 0);
        pop_rx(got);
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;

        // R6 framing error
        drive_frame(8'h5A, 8, 0, 0, 0);
        check(err_frame == 1'b1 && err_break == 1'b0, "R6 framing", {err_frame, err_break}, 2);
        pop_rx(got);
        check(got == 8'h5A, "R6 byte kept", got, 8'h5A);
        clear_errs();

        // R7 break
        drive_frame(8'h00, 8, 0, 0, 0);
        check(err_break == 1'b1 && err_frame == 1'b0, "R7 break flag", {err_break, err_frame}, 2);
        check(rx_count == 0, "R7 no byte stored", rx_count, 0);
        clear_errs();
        check(err_break == 1'b0, "R12 flag cleared", err_break, 0);

        // R11 short glitch rejected
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (6) @(negedge clk);
        rx_drv = 1'b1;
        repeat (3 * bit_time()) @(negedge clk);
        check(rx_count == 0 && err_frame == 0, "R11 glitch ignored", rx_count, 0);

        // R8 overrun, R10 rts threshold
        do_reset();
        rts_level = 7'd3;
        for (int i = 0; i < 64; i++) begin
            drive_frame(8'(i + 1), 8, 0, 0, 1);
            if (i == 1) check(rts == 1'b1, "R10 rts high below level", rts, 1);
            if (i == 2) check(rts == 1'b0, "R10 rts low at level", rts, 0);
        end
        check(rx_full == 1'b1 && err_overrun == 1'b0, "R1 rx full", {rx_full, err_overrun}, 2);
        drive_frame(8'hEE, 8, 0, 0, 1);
        check(err_overrun == 1'b1, "R8 overrun flag", err_overrun, 1);
        check(rx_count == 64, "R8 count kept", rx_count, 64);
        pop_rx(got);
        check(got == 8'h01, "R8 oldest preserved", got, 8'h01);
        check(rx_ready == 1'b1, "R1 ready after pop", rx_ready, 1);

        // Random loopback batches, R2 R3 R4
        do_reset();
        loop = 1'b1;
        for (int b = 0; b < 4; b++) begin
            int flen;
            cfg_data7   = 1'($urandom % 2);
            cfg_par_en  = 1'($urandom % 2);
            cfg_par_odd = 1'($urandom % 2);
            cfg_stop2   = 1'($urandom % 2);
            baud_div    = 16'(1 + $urandom % 2);
            bt = bit_time();
            flen = 1 + (cfg_data7 ? 7 : 8) + int'(cfg_par_en) + (cfg_stop2 ? 2 : 1);
            for (int i = 0; i < 6; i++) begin
                expq[i] = 8'($urandom);
                push_tx(expq[i]);
            end
            repeat (6 * flen * bt + 4 * bt) @(negedge clk);
            check(rx_count == 6, "R1 loopback count", rx_count, 6);
            check(err_parity == 0 && err_frame == 0, "R3 loopback no error",
                  {err_parity, err_frame}, 0);
            for (int i = 0; i < 6; i++) begin
                logic [7:0] e;
                e = cfg_data7 ? {1'b0, expq[i][6:0]} : expq[i];
                pop_rx(got);
                check(got == e, "R4 loopback byte", got, e);
            end
        end

        // R5 external clock source
        do_reset();
        cfg_data7 = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_stop2 = 0;
        baud_div = 16'd1;
        cfg_ext_clk = 1'b1;
        bt = bit_time();
        push_tx(8'h96);
        push_tx(8'h4B);
        n = 0;
        for (int i = 0; i < 22 * bt; i++) begin
            @(negedge clk);
            if (tick_out) n++;
        end
        check(n == 0, "R5 no tick_out in external mode", n, 0);
        pop_rx(got);
        check(got == 8'h96, "R5 external loopback 1", got, 8'h96);
        pop_rx(got);
        check(got == 8'h4B, "R5 external loopback 2", got, 8'h4B);

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule